// File: doc/BRIEF.md
# Audio Serial Clock Regenerator

This block rebuilds the bit clock and the word clock of a stereo serial audio link from a master clock and nothing else. A host that drives the same master clock also sends its own bit and word clocks, but those may be degraded. Here the host bit clock is not used at all. The host word clock is used only once, to set the phase of the local frame. A binary counter, clocked by the master clock, produces both output clocks. The host serial data line is forwarded to the output, retimed so that it changes with the regenerated bit clock.

The master clock runs at 512 times the sample rate. The word clock is the most significant bit of a 9-bit counter. The bit clock is counter bit 2, which gives 64 bit clocks per frame. After reset the counter runs freely and waits for a trigger. The first falling edge of the host word clock passes through a two-flop synchronizer and then loads the counter with a value that cancels the synchronizer delay. At that point the lock flag is set. While locked, further host word-clock edges are ignored. A re-arm pulse clears the flag and waits for a new trigger. The block has no rate setting: the 44.1 kHz and 48 kHz families differ only in the master clock that is supplied.

Top module: `i2s_clock_regen`

## Requirements
- R1: While rst_ni is low, bclk_o, ws_o, sd_o and locked_o are all 0.
- R2: Once locked, bclk_o has a period of exactly 8 mclk_i cycles and stays high for 4 of them.
- R3: Once locked, ws_o has a period of 512 mclk_i cycles. It changes only in a cycle where bclk_o falls, and each half-frame contains exactly 32 bclk_o falling edges.
- R4: Let k be the first mclk_i rising edge that samples host_ws_i low after it was high, while unlocked. Then ws_o falls at edge k+512. Without such a falling edge the block never locks.
- R5: locked_o rises at edge k+2, two edges after k, and only as the result of a detected host word-clock falling edge.
- R6: While locked_o is 1, the counter increments by one on every edge, and host_ws_i transitions do not change the ws_o phase.
- R7: A rearm_i pulse sampled at an edge clears locked_o at that edge. If a falling edge is detected in the same cycle, rearm_i takes priority. Until the next trigger, the counter keeps its old phase. The next host falling edge realigns the counter as in R4 and R5.
- R8: sd_o takes the host_sd_i value sampled at the mclk_i edge where bclk_o falls, and holds that value at every other edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mclk_i | input | 1 | Master audio clock, 512x sample rate |
| rst_ni | input | 1 | Active-low asynchronous reset |
| host_ws_i | input | 1 | Host word clock, used only as an alignment trigger |
| host_sd_i | input | 1 | Host serial data, synchronous to mclk_i |
| rearm_i | input | 1 | Drop lock and wait for a new trigger |
| bclk_o | output | 1 | Regenerated bit clock (mclk/8) |
| ws_o | output | 1 | Regenerated word clock (mclk/512) |
| sd_o | output | 1 | Serial data retimed to bclk_o falling edges |
| locked_o | output | 1 | Frame phase aligned to host |

## Verification
The assertions check several properties on every cycle. The reset levels must hold. The counter must step by one while locked. The word clock and the data may change only on a bit-clock falling edge. A lock must load the compensating count and must follow a detected host edge. A re-arm must drop the lock. Some properties are visible only at the ports, so only the bench scenarios can show them. These are the absolute frame phase after a trigger, measured 512 edges later. They also include the immunity to host word-clock toggles during lock, the preserved phase between re-arm and the next trigger, the realignment to a new offset, and the exact data value carried across each bit-clock fall.

// File: rtl/i2s_regen_pkg.sv
package i2s_regen_pkg;
  localparam int unsigned CNT_W_DEF    = 9;  // MCLK/512 frame
  localparam int unsigned BCLK_BIT_DEF = 2;  // MCLK/8 bit clock
  localparam int unsigned SYNC_N_DEF   = 2;  // synchronizer depth, >= 2
endpackage

// File: rtl/i2s_ws_sync.sv
module i2s_ws_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ws_i,
  output logic fall_o
);
  logic [STAGES-1:0] sync_q;
  logic              last_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      last_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], ws_i};
      last_q <= sync_q[STAGES-1];
    end
  end

  assign fall_o = last_q & ~sync_q[STAGES-1];
endmodule

// File: rtl/i2s_div_counter.sv
module i2s_div_counter #(
  parameter int unsigned W   = 9,
  parameter int unsigned TAP = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  output logic [W-1:0] cnt_o,
  output logic         tap_next_o
);
  localparam logic [W-1:0] ONE = W'(1);
  logic [W-1:0] cnt_d;

  always_comb cnt_d = load_i ? load_val_i : cnt_o + ONE;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_o <= '0;
    else         cnt_o <= cnt_d;
  end

  assign tap_next_o = cnt_d[TAP];
endmodule

// File: rtl/i2s_sd_retime.sv
module i2s_sd_retime (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic upd_i,
  input  logic sd_i,
  output logic sd_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    sd_o <= 1'b0;
    else if (upd_i) sd_o <= sd_i;
  end
endmodule

// File: rtl/i2s_clock_regen.sv
module i2s_clock_regen
  import i2s_regen_pkg::*;
#(
  parameter int unsigned CNT_W    = CNT_W_DEF,
  parameter int unsigned BCLK_BIT = BCLK_BIT_DEF,
  parameter int unsigned SYNC_N   = SYNC_N_DEF
) (
  input  logic mclk_i,
  input  logic rst_ni,
  input  logic host_ws_i,
  input  logic host_sd_i,
  input  logic rearm_i,
  output logic bclk_o,
  output logic ws_o,
  output logic sd_o,
  output logic locked_o
);
  // host fall seen SYNC_N edges late: preload that many counts
  localparam logic [CNT_W-1:0] LOAD_VAL = CNT_W'(SYNC_N);

  logic             ws_fall;
  logic             do_load;
  logic             bclk_next;
  logic [CNT_W-1:0] div_cnt;

  i2s_ws_sync #(.STAGES(SYNC_N)) u_sync (
    .clk_i  (mclk_i),
    .rst_ni (rst_ni),
    .ws_i   (host_ws_i),
    .fall_o (ws_fall)
  );

  assign do_load = ws_fall & ~locked_o & ~rearm_i;

  always_ff @(posedge mclk_i or negedge rst_ni) begin
    if (!rst_ni)      locked_o <= 1'b0;
    else if (rearm_i) locked_o <= 1'b0;
    else if (do_load) locked_o <= 1'b1;
  end

  i2s_div_counter #(.W(CNT_W), .TAP(BCLK_BIT)) u_cnt (
    .clk_i      (mclk_i),
    .rst_ni     (rst_ni),
    .load_i     (do_load),
    .load_val_i (LOAD_VAL),
    .cnt_o      (div_cnt),
    .tap_next_o (bclk_next)
  );

  assign bclk_o = div_cnt[BCLK_BIT];
  assign ws_o   = div_cnt[CNT_W-1];

  i2s_sd_retime u_sd (
    .clk_i  (mclk_i),
    .rst_ni (rst_ni),
    .upd_i  (bclk_o & ~bclk_next),
    .sd_i   (host_sd_i),
    .sd_o   (sd_o)
  );
endmodule

// File: rtl/i2s_clock_regen_chk.sv
module i2s_clock_regen_chk #(
  parameter int unsigned CNT_W  = 9,
  parameter int unsigned SYNC_N = 2
) (
  input logic             mclk_i,
  input logic             rst_ni,
  input logic             rearm_i,
  input logic             bclk_o,
  input logic             ws_o,
  input logic             sd_o,
  input logic             locked_o,
  input logic             ws_fall_i,
  input logic [CNT_W-1:0] cnt_i
);
  AST_RESET_QUIET: assert property (@(posedge mclk_i)
    !rst_ni |-> (!bclk_o && !ws_o && !sd_o && !locked_o)); // R1

  AST_WS_ON_BCLK_FALL: assert property (@(posedge mclk_i) disable iff (!rst_ni)
    (!$rose(locked_o) && !$stable(ws_o)) |-> $fell(bclk_o)); // R3

  AST_LOCK_LOAD: assert property (@(posedge mclk_i) disable iff (!rst_ni)
    $rose(locked_o) |-> (cnt_i == CNT_W'(SYNC_N))); // R4

  AST_LOCK_NEEDS_FALL: assert property (@(posedge mclk_i) disable iff (!rst_ni)
    $rose(locked_o) |-> $past(ws_fall_i)); // R5

  AST_FREE_RUN: assert property (@(posedge mclk_i) disable iff (!rst_ni)
    (locked_o && $past(locked_o)) |-> (cnt_i == $past(cnt_i) + CNT_W'(1))); // R6

  AST_REARM_DROP: assert property (@(posedge mclk_i) disable iff (!rst_ni)
    rearm_i |=> !locked_o); // R7

  AST_SD_ON_BCLK_FALL: assert property (@(posedge mclk_i) disable iff (!rst_ni)
    !$stable(sd_o) |-> $fell(bclk_o)); // R8
endmodule

bind i2s_clock_regen i2s_clock_regen_chk #(.CNT_W(CNT_W), .SYNC_N(SYNC_N)) u_chk (
  .mclk_i    (mclk_i),
  .rst_ni    (rst_ni),
  .rearm_i   (rearm_i),
  .bclk_o    (bclk_o),
  .ws_o      (ws_o),
  .sd_o      (sd_o),
  .locked_o  (locked_o),
  .ws_fall_i (ws_fall),
  .cnt_i     (div_cnt)
);

// File: tb/i2s_clock_regen_bench.sv
`timescale 1ns/1ps
module i2s_clock_regen_bench;
  logic mclk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic host_ws_i = 1'b1;
  logic host_sd_i = 1'b0;
  logic rearm_i = 1'b0;
  logic bclk_o, ws_o, sd_o, locked_o;

  int errors = 0;
  int checks = 0;
  int edge_n = 0;
  bit done = 1'b0;
  bit sb_q[$];
  logic [15:0] lfsr = 16'hACE1;

  i2s_clock_regen u_i2s_clock_regen (
    .mclk_i, .rst_ni, .host_ws_i, .host_sd_i, .rearm_i,
    .bclk_o, .ws_o, .sd_o, .locked_o
  );

  always #10 mclk_i = ~mclk_i;
  always @(posedge mclk_i) edge_n <= edge_n + 1;

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s at edge %0d: actual=%0d expected=%0d", tag, edge_n, act, exp);
    end
  endtask

  task automatic goto(input int target);
    while (edge_n < target) begin
      @(posedge mclk_i);
      #5;
    end
  endtask

  // driver: pseudo-random host data, one scoreboard entry per edge
  always @(negedge mclk_i) begin
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    host_sd_i = lfsr[0];
    sb_q.push_back(lfsr[0]);
  end

  // monitor
  bit prev_b = 0, prev_ws = 0, prev_sd = 0, prev_lk = 0;
  int lst_rise = -1, lst_fall = -1, nfalls = -1;
  always @(posedge mclk_i) begin
    bit exp_sd, bfell, brose;
    #5;
    exp_sd = sb_q.pop_front();
    if (!rst_ni) begin
      prev_b = 0; prev_ws = 0; prev_sd = 0; prev_lk = 0;
      lst_rise = -1; lst_fall = -1; nfalls = -1;
    end else begin
      bfell = prev_b && !bclk_o;
      brose = !prev_b && bclk_o;
      if (bfell) check(sd_o == exp_sd, "R8 sd at bclk fall", sd_o, exp_sd);
      else       check(sd_o == prev_sd, "R8 sd hold", sd_o, prev_sd);
      if (locked_o && prev_lk) begin
        if (brose) lst_rise = edge_n;
        if (bfell) begin
          if (lst_fall >= 0) check(edge_n - lst_fall == 8, "R2 bclk period", edge_n - lst_fall, 8);
          if (lst_rise >= 0) check(edge_n - lst_rise == 4, "R2 bclk high time", edge_n - lst_rise, 4);
          lst_fall = edge_n;
          if (nfalls >= 0) nfalls++;
        end
        if (ws_o != prev_ws) begin
          check(bfell, "R3 ws moves on bclk fall", bfell, 1);
          if (nfalls >= 0) check(nfalls == 32, "R3 bclk per half frame", nfalls, 32);
          nfalls = 0;
        end
      end else begin
        lst_rise = -1; lst_fall = -1; nfalls = -1;
      end
      prev_b = bclk_o; prev_ws = ws_o; prev_sd = sd_o; prev_lk = locked_o;
    end
  end

  initial begin
    #4_000_000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=hung expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int k, k2, e;
    sb_q.push_back(1'b0);
    repeat (3) @(posedge mclk_i);
    #5;
    check(bclk_o == 0, "R1 bclk in reset", bclk_o, 0);
    check(ws_o == 0, "R1 ws in reset", ws_o, 0);
    check(sd_o == 0, "R1 sd in reset", sd_o, 0);
    check(locked_o == 0, "R1 locked in reset", locked_o, 0);
    @(negedge mclk_i) rst_ni = 1'b1;

    goto(edge_n + 20);
    check(locked_o == 0, "R4 no lock without trigger", locked_o, 0);

    k = edge_n + 5;
    goto(k - 1);
    @(negedge mclk_i) host_ws_i = 1'b0;
    goto(k);     check(locked_o == 0, "R5 lock latency k", locked_o, 0);
    goto(k + 1); check(locked_o == 0, "R5 lock latency k+1", locked_o, 0);
    goto(k + 2); check(locked_o == 1, "R5 locked at k+2", locked_o, 1);
    goto(k + 511); check(ws_o == 1, "R4 ws before aligned fall", ws_o, 1);
    goto(k + 512); check(ws_o == 0, "R4 ws aligned fall", ws_o, 0);

    goto(k + 600);
    for (int i = 0; i < 5; i++) begin
      @(negedge mclk_i) host_ws_i = ~host_ws_i;
      repeat (37) @(negedge mclk_i);
    end
    #15;
    check(locked_o == 1, "R6 still locked", locked_o, 1);
    goto(k + 1023); check(ws_o == 1, "R6 phase kept (high)", ws_o, 1);
    goto(k + 1024); check(ws_o == 0, "R6 phase kept (fall)", ws_o, 0);

    e = k + 1100;
    goto(e - 1);
    @(negedge mclk_i) rearm_i = 1'b1;
    @(negedge mclk_i) rearm_i = 1'b0;
    check(locked_o == 0, "R7 rearm clears lock", locked_o, 0);
    goto(k + 1535); check(ws_o == 1, "R7 old phase high", ws_o, 1);
    check(locked_o == 0, "R7 waits for trigger", locked_o, 0);
    goto(k + 1536); check(ws_o == 0, "R7 old phase fall", ws_o, 0);

    k2 = k + 1700;
    goto(k2 - 1);
    @(negedge mclk_i) host_ws_i = 1'b0;
    goto(k2 + 1); check(locked_o == 0, "R7 relock latency", locked_o, 0);
    goto(k2 + 2); check(locked_o == 1, "R7 relocked", locked_o, 1);
    goto(k2 + 511); check(ws_o == 1, "R7 new phase high", ws_o, 1);
    goto(k2 + 512); check(ws_o == 0, "R7 new phase fall", ws_o, 0);

    goto(k2 + 1300);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule